// File: doc/BRIEF.md
# Packed Color Palette Lookup

This block holds a 256-color palette and turns an 8-bit pixel index into a 24-bit RGB color. The palette lives in 128 words of 32 bits, and each word carries two 16-bit color entries. A bus side writes and reads whole words, so software can load two colors with one access. A pixel side presents an index every cycle and receives the expanded color one cycle later.

Each 16-bit entry packs three 5-bit channels and one intensity bit. The pixel path drops the intensity bit. It widens each channel to 8 bits by appending three zero bits, and it can exchange the red and blue channels under a control input. That input serves displays that expect blue in the upper byte.

Top module: `pal_lookup`

## Requirements
- R1: A bus write with `bus_we` high stores all 32 bits of `bus_wdata` into word `bus_addr`. `bus_rdata` is registered: on the cycle after the address is presented it holds the word as it was before any write in that same cycle.
- R2: Palette index `i` selects word `i[7:1]`. Even indices use bits [15:0] of that word and odd indices use bits [31:16].
- R3: Within an entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. With the swap input low, `pix_rgb` is {red, green, blue} in bits [23:16], [15:8] and [7:0]. Each output channel equals its 5-bit field multiplied by 8, so its low three bits are zero.
- R4: Bit 15 of an entry, the intensity bit, has no effect on `pix_rgb`. A bus read still returns it unchanged.
- R5: When `swap_rb` is high in the lookup cycle, `pix_rgb[23:16]` carries blue and `pix_rgb[7:0]` carries red. Green is unchanged.
- R6: `pix_rgb` shows the color for the index and swap value presented one cycle earlier. A lookup sees a word written in an earlier cycle. A lookup in the same cycle as a write to its word sees the old contents.
- R7: While `rst_n` is low at a clock edge, `pix_rgb` and `bus_rdata` are cleared to zero. Palette contents are not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Word write strobe |
| bus_addr | input | 7 | Word address for reads and writes |
| bus_wdata | input | 32 | Word to write, two packed entries |
| bus_rdata | output | 32 | Registered raw word read back |
| pix_idx | input | 8 | Palette index for lookup |
| swap_rb | input | 1 | Exchange red and blue on the output |
| pix_rgb | output | 24 | Expanded color, one cycle after the index |

## Verification
The embedded assertions check several properties on every cycle. They check that a written word reads back intact on the next access to the same address. They check that a lookup of a just-written word returns the correctly expanded half with the intensity bit dropped. They check that toggling the swap input on an unchanged entry exchanges the outer bytes, and that reset clears both outputs. Other behaviours need the bench's scenarios to show. These are the even/odd half selection across the full index range, and the old-value result when a write and a lookup hit the same word in one cycle. They also include the intensity bit surviving a bus read, and the contents surviving a reset. The bench compares these against its behavioural reference on every clock.

// File: rtl/pal_lookup.sv
module pal_lookup #(
  parameter int IDX_W  = 8,
  parameter int CH_W   = 5,
  parameter int OUT_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [IDX_W-2:0]       bus_addr,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  input  logic [IDX_W-1:0]       pix_idx,
  input  logic                   swap_rb,
  output logic [3*OUT_W-1:0]     pix_rgb
);
  localparam int ENT_W  = WORD_W / 2;
  localparam int ADDR_W = IDX_W - 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SHIFT  = OUT_W - CH_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk)
    if (bus_we) mem[bus_addr] <= bus_wdata;

  logic [WORD_W-1:0] word_q;
  logic [ENT_W-1:0]  entry;
  logic [OUT_W-1:0]  red_x, grn_x, blu_x;

  assign word_q = mem[pix_idx[IDX_W-1:1]];
  assign entry  = pix_idx[0] ? word_q[WORD_W-1:ENT_W] : word_q[ENT_W-1:0];
  assign red_x  = {entry[CH_W-1:0],        {SHIFT{1'b0}}};
  assign grn_x  = {entry[2*CH_W-1:CH_W],   {SHIFT{1'b0}}};
  assign blu_x  = {entry[3*CH_W-1:2*CH_W], {SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_rgb   <= '0;
      bus_rdata <= '0;
    end else begin
      pix_rgb   <= swap_rb ? {blu_x, grn_x, red_x} : {red_x, grn_x, blu_x};
      bus_rdata <= mem[bus_addr];
    end
  end

  function automatic logic [3*OUT_W-1:0] golden(input logic [WORD_W-1:0] w,
                                                input logic odd, input logic sw);
    int unsigned e, r, g, b;
    e = odd ? int'(w >> ENT_W) : int'(w);
    r = (e % (1 << CH_W)) * (1 << SHIFT);
    g = ((e >> CH_W) % (1 << CH_W)) * (1 << SHIFT);
    b = ((e >> (2*CH_W)) % (1 << CH_W)) * (1 << SHIFT);
    if (sw) golden = {b[OUT_W-1:0], g[OUT_W-1:0], r[OUT_W-1:0]};
    else    golden = {r[OUT_W-1:0], g[OUT_W-1:0], b[OUT_W-1:0]};
  endfunction

  // R1: written word returns on the next read of the same address
  a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(bus_we, 2) && $past(bus_addr, 2) == $past(bus_addr, 1))
    |-> bus_rdata == $past(bus_wdata, 2));

  // R3 R4 R6: lookup right after a write returns the expanded half
  a_r6_write_then_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(bus_we, 2) && $past(pix_idx[IDX_W-1:1], 1) == $past(bus_addr, 2))
    |-> pix_rgb == golden($past(bus_wdata, 2), $past(pix_idx[0], 1), $past(swap_rb, 1)));

  // R5: toggling swap on an unchanged entry exchanges the outer bytes
  a_r5_swap_exchange: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 1) && $past(rst_n, 2) && !$past(bus_we, 2) &&
     $past(pix_idx, 1) == $past(pix_idx, 2) && $past(swap_rb, 1) != $past(swap_rb, 2))
    |-> pix_rgb == {$past(pix_rgb[OUT_W-1:0]), $past(pix_rgb[2*OUT_W-1:OUT_W]),
                    $past(pix_rgb[3*OUT_W-1:2*OUT_W])});

  // R7: outputs are zero after a reset edge
  a_r7_reset_clear: assert property (@(posedge clk)
    $past(!rst_n) |-> (pix_rgb == '0 && bus_rdata == '0));
endmodule

// File: tb/pal_lookup_tb.sv
`timescale 1ns/1ps
module pal_lookup_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [6:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = 0;
  logic        swap_rb = 0;
  logic [23:0] pix_rgb;

  pal_lookup dut_i (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pix_idx(pix_idx),
    .swap_rb(swap_rb), .pix_rgb(pix_rgb));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  string tag = "R7";
  bit    finished = 0;

  int unsigned model [128];
  bit          known [128];
  int unsigned exp_rgb, exp_rd;
  bit          rgb_ok, rd_ok, armed;

  initial begin
    for (int i = 0; i < 128; i++) known[i] = 0;
    armed = 0;
  end

  always @(posedge clk) begin
    int unsigned w, e, r, g, b;
    if (!rst_n) begin
      exp_rgb = 0; exp_rd = 0; rgb_ok = 1; rd_ok = 1;
    end else begin
      w = model[pix_idx / 2];
      e = (pix_idx % 2) ? (w / 65536) : (w % 65536);
      r = (e % 32) * 8;
      g = ((e / 32) % 32) * 8;
      b = ((e / 1024) % 32) * 8;
      exp_rgb = swap_rb ? (b * 65536 + g * 256 + r) : (r * 65536 + g * 256 + b);
      rgb_ok  = known[pix_idx / 2];
      exp_rd  = model[bus_addr];
      rd_ok   = known[bus_addr];
      if (bus_we) begin
        model[bus_addr] = bus_wdata;
        known[bus_addr] = 1;
      end
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed && !finished) begin
      if (rgb_ok) begin
        checks++;
        if (pix_rgb !== exp_rgb[23:0]) begin
          errors++;
          $display("FAIL %s pix_rgb actual=%h expected=%h", tag, pix_rgb, exp_rgb[23:0]);
        end
      end
      if (rd_ok) begin
        checks++;
        if (bus_rdata !== exp_rd) begin
          errors++;
          $display("FAIL %s bus_rdata actual=%h expected=%h", tag, bus_rdata, exp_rd);
        end
      end
    end
  end

  task automatic step(input bit we, input int a, input int unsigned d,
                      input int idx, input bit sw);
    @(negedge clk);
    bus_we = we; bus_addr = a[6:0]; bus_wdata = d; pix_idx = idx[7:0]; swap_rb = sw;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state checked by the per-cycle compare above
    tag = "R1";
    rst_n = 1;
    for (int a = 0; a < 128; a++)
      step(1, a, 32'h8000_8000 ^ (a * 32'h0107_0B13), 0, 0);
    for (int a = 0; a < 128; a++) step(0, a, 0, 0, 0);

    tag = "R2 R3";
    for (int i = 0; i < 256; i++) step(0, 127 - i / 2, 0, i, 0);

    tag = "R4";
    step(1, 5, 32'hFFFF_7FFF, 0, 0);
    step(1, 6, 32'h7FFF_FFFF, 0, 0);
    for (int i = 10; i < 14; i++) step(0, 5 + (i % 2), 0, i, 0);
    step(0, 5, 0, 0, 0);
    step(0, 6, 0, 0, 0);

    tag = "R5";
    step(1, 9, 32'h001F_7C00, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 9, 0, 18 + (i / 2) % 2, i % 2);
    for (int i = 0; i < 40; i++) step(0, i, 0, 3 * i + 1, (i % 3) == 0);

    tag = "R6";
    step(1, 20, 32'h1234_5678, 40, 0);
    step(1, 20, 32'h0ACE_4321, 41, 1);
    step(0, 20, 0, 40, 0);
    step(0, 20, 0, 41, 0);
    for (int i = 0; i < 200; i++)
      step(i % 3 != 0, (i * 37) % 128, (i * 32'h9E37_79B9) ^ 32'hA5A5_5A5A,
           (i * 73 + 11) % 256, (i % 5) < 2);

    tag = "R7";
    step(1, 30, 32'h0000_03E0, 60, 0);
    step(0, 30, 0, 60, 0);
    rst_n = 0;
    step(0, 30, 0, 60, 0);
    step(0, 30, 0, 60, 0);
    rst_n = 1;
    step(0, 30, 0, 60, 0);
    step(0, 30, 0, 61, 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule